// File: doc/BRIEF.md
# Valley Turn-On Sequencer With Substitute Timeout

This block times the next power-switch turn-on of a quasi-resonant converter. Each switching period ends with a driver-off event. After that event the block first holds a blanking window, during which the zero-cross comparator output is disregarded, because ringing right after turn-off is not a valley. Once the window closes, each falling transition of the synchronized comparator bit counts as one valley.

A timeout timer keeps the count moving when the drain ringing is too damped for the comparator to trip. If no valley arrives within the timeout, the timer produces a substitute valley and starts again. While soft-start is active a longer timeout applies, which lets the transformer fully demagnetize before the next turn-on. When the valley count reaches the valley number chosen by the mode selector, the block emits a single-cycle turn-on pulse. It then waits for the next driver-off event.

All durations are parameters in clock cycles. The comparator bit is asynchronous and passes through a two-flop synchronizer inside the block.

Top module: `valley_turnon_seq`

## Requirements
- R1: After reset `turn_on_o` is low, and no turn-on pulse occurs before the first driver-off event, whatever `zcd_i` does.
- R2: Falling transitions of `zcd_i` seen during the `BLANK_CYC` cycles that follow a driver-off event are not counted as valleys.
- R3: `valley_sel_i` picks the target valley: code 0 selects the 1st, 1 the 2nd, 2 the 3rd and 3 the 4th. The turn-on pulse is issued on the event that brings the valley count to that number.
- R4: `turn_on_o` is high for exactly one cycle, and at most once per off-period. Further valleys after the pulse have no effect until the next driver-off event.
- R5: In normal operation, if `TMO_CYC` cycles pass after the end of blanking or after the last valley event without a counted valley, a substitute valley is counted and the timer restarts. A real valley and a timeout in the same cycle count as one event.
- R6: While `soft_start_i` is high, the timeout length is `TMO_SS_CYC` instead of `TMO_CYC`.
- R7: A driver-off event at any time clears the valley count and both timers and restarts blanking.
- R8: A falling transition on `zcd_i` that is driven before clock edge k is counted at edge k+2, so a pulse it triggers is visible after edge k+2. Rising transitions are never counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| zcd_i | input | 1 | Asynchronous zero-cross comparator output |
| drv_off_i | input | 1 | Single-cycle pulse marking the end of on-time |
| valley_sel_i | input | 2 | Target valley, code 0..3 for valley 1..4 |
| soft_start_i | input | 1 | Selects the extended timeout |
| turn_on_o | output | 1 | Single-cycle turn-on request |

## Verification
The driver-off edge is counted as edge 0, so blanking ends at edge `BLANK_CYC`. A timeout lands `TMO_CYC` (or `TMO_SS_CYC`) edges after the previous event, and a comparator fall driven before edge k is counted at edge k+2. The bench predicts the edge number of every pulse from these rules, measures the edge number of the pulse it actually sees, and compares the two exactly. It also counts the pulse width in cycles, so both an early or late pulse and a stretched or repeated one are reported.

// File: rtl/vts_pkg.sv
package vts_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BLANK = 2'd1,
        ST_COUNT = 2'd2,
        ST_DONE  = 2'd3
    } vts_state_e;

    typedef struct packed {
        vts_state_e state;
        logic [2:0] vcnt;
        logic       turn_on;
    } vts_ctl_s;

endpackage

// File: rtl/vts_edge.sv
module vts_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic fall_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } edge_s;

    edge_s reg_d, reg_q;

    always_comb begin
        reg_d    = reg_q;
        reg_d.s1 = async_i;
        reg_d.s2 = reg_q.s1;
        reg_d.s3 = reg_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    assign fall_o = reg_q.s3 & ~reg_q.s2;

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o); // R8

endmodule

// File: rtl/vts_timer.sv
module vts_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         en_i,
    input  logic [W-1:0] limit_i,
    output logic         hit_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        hit_o = en_i && !clr_i && (cnt_q >= limit_i - W'(1));
        cnt_d = cnt_q;
        if (clr_i || hit_o) cnt_d = '0;
        else if (en_i)      cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TMR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0)); // R7
    AST_TMR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |=> (cnt_q == '0)); // R5

endmodule

// File: rtl/valley_turnon_seq.sv
module valley_turnon_seq
    import vts_pkg::*;
#(
    parameter int BLANK_CYC  = 315,
    parameter int TMO_CYC    = 550,
    parameter int TMO_SS_CYC = 4000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       zcd_i,
    input  logic       drv_off_i,
    input  logic [1:0] valley_sel_i,
    input  logic       soft_start_i,
    output logic       turn_on_o
);
    localparam int MAX_A = (TMO_SS_CYC > TMO_CYC) ? TMO_SS_CYC : TMO_CYC;
    localparam int MAX_C = (MAX_A > BLANK_CYC) ? MAX_A : BLANK_CYC;
    localparam int TW    = $clog2(MAX_C + 1);

    vts_ctl_s ctl_d, ctl_q;

    logic          zcd_fall;
    logic          fall_vld;
    logic          blank_hit;
    logic          tmo_hit;
    logic          valley_ev;
    logic [TW-1:0] tmo_limit;

    vts_edge i_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (zcd_i),
        .fall_o  (zcd_fall)
    );

    vts_timer #(.W(TW)) i_blank_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (drv_off_i || (ctl_q.state != ST_BLANK)),
        .en_i    (ctl_q.state == ST_BLANK),
        .limit_i (TW'(BLANK_CYC)),
        .hit_o   (blank_hit)
    );

    assign tmo_limit = soft_start_i ? TW'(TMO_SS_CYC) : TW'(TMO_CYC);
    assign fall_vld  = zcd_fall && (ctl_q.state == ST_COUNT) && !drv_off_i;

    vts_timer #(.W(TW)) i_tmo_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (drv_off_i || (ctl_q.state != ST_COUNT) || fall_vld),
        .en_i    (ctl_q.state == ST_COUNT),
        .limit_i (tmo_limit),
        .hit_o   (tmo_hit)
    );

    assign valley_ev = fall_vld || tmo_hit;

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.turn_on = 1'b0;
        if (drv_off_i) begin
            ctl_d.state = ST_BLANK;
            ctl_d.vcnt  = '0;
        end else begin
            unique case (ctl_q.state)
                ST_BLANK: if (blank_hit) ctl_d.state = ST_COUNT;
                ST_COUNT: if (valley_ev) begin
                    ctl_d.vcnt = ctl_q.vcnt + 3'd1;
                    if (ctl_q.vcnt == {1'b0, valley_sel_i}) begin
                        ctl_d.turn_on = 1'b1;
                        ctl_d.state   = ST_DONE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{state: ST_IDLE, vcnt: '0, turn_on: 1'b0};
        else        ctl_q <= ctl_d;
    end

    assign turn_on_o = ctl_q.turn_on;

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        turn_on_o |=> !turn_on_o); // R4
    AST_PULSE_FROM_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(turn_on_o) |-> ($past(ctl_q.state) == ST_COUNT)); // R4
    AST_NO_PULSE_AFTER_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_BLANK) |=> !turn_on_o); // R2
    AST_VCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.vcnt <= 3'd4); // R3
    AST_DRVOFF_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        drv_off_i |=> (ctl_q.state == ST_BLANK) && (ctl_q.vcnt == 3'd0)); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_IDLE) |-> !turn_on_o); // R1

endmodule

// File: tb/test_valley_turnon_seq.sv
module test_valley_turnon_seq;
    localparam int BL = 20;
    localparam int TM = 40;
    localparam int TS = 160;
    localparam int NV = 10;

    // {sel[2], ss[1], nfall[4], t0[8], spacing[8], expected edge[16]}
    localparam logic [38:0] VEC [NV] = '{
        {2'd0, 1'b0, 4'd1, 8'd30, 8'd25, 16'd33},   // R3 valley 1
        {2'd1, 1'b0, 4'd3, 8'd30, 8'd15, 16'd48},   // R3 valley 2
        {2'd3, 1'b0, 4'd4, 8'd30, 8'd10, 16'd63},   // R3 valley 4
        {2'd2, 1'b0, 4'd0, 8'd0,  8'd0,  16'd140},  // R5 all substitutes
        {2'd1, 1'b0, 4'd2, 8'd5,  8'd10, 16'd100},  // R2 falls inside blanking
        {2'd3, 1'b0, 4'd1, 8'd30, 8'd0,  16'd153},  // R5 real then substitutes
        {2'd0, 1'b1, 4'd0, 8'd0,  8'd0,  16'd180},  // R6 long timeout
        {2'd2, 1'b1, 4'd2, 8'd30, 8'd20, 16'd213},  // R6 mixed
        {2'd3, 1'b0, 4'd6, 8'd30, 8'd8,  16'd57},   // R4 extra falls ignored
        {2'd2, 1'b0, 4'd2, 8'd37, 8'd40, 16'd120}   // R5 coincident events
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       zcd = 1'b1;
    logic       drv_off = 1'b0;
    logic [1:0] vsel = 2'd0;
    logic       ss = 1'b0;
    logic       turn_on;

    int cyc = 0;
    int pulse_cnt = 0;
    int pulse_cyc = -1;
    int base = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    valley_turnon_seq #(.BLANK_CYC(BL), .TMO_CYC(TM), .TMO_SS_CYC(TS)) i_valley_turnon_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .zcd_i        (zcd),
        .drv_off_i    (drv_off),
        .valley_sel_i (vsel),
        .soft_start_i (ss),
        .turn_on_o    (turn_on)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (turn_on) begin
            pulse_cnt = pulse_cnt + 1;
            pulse_cyc = cyc;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_to(input int abs_cyc);
        while (cyc < abs_cyc) @(negedge clk);
    endtask

    task automatic start_off();
        @(negedge clk);
        pulse_cnt = 0;
        pulse_cyc = -1;
        drv_off   = 1'b1;
        base      = cyc + 1;
        @(negedge clk);
        drv_off   = 1'b0;
    endtask

    task automatic run_vec(input logic [38:0] v);
        int n;
        int t0;
        int sp;
        vsel = v[38:37];
        ss   = v[36];
        n    = int'(v[35:32]);
        t0   = int'(v[31:24]);
        sp   = int'(v[23:16]);
        start_off();
        for (int i = 0; i < n; i++) begin
            wait_to(base + t0 + i * sp);
            zcd = 1'b0;
            wait_to(base + t0 + i * sp + 4);
            zcd = 1'b1;
        end
        wait_to(base + 260);
        check("R3/R5/R8 pulse edge", pulse_cyc - base, int'(v[15:0]));
        check("R4 pulse cycles", pulse_cnt, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset output", int'(turn_on), 0);
        rst_n = 1'b1;
        // R1: comparator activity without driver-off gives no pulse
        for (int i = 0; i < 5; i++) begin
            repeat (6) @(negedge clk);
            zcd = 1'b0;
            repeat (6) @(negedge clk);
            zcd = 1'b1;
        end
        repeat (20) @(negedge clk);
        check("R1 no pulse before driver-off", pulse_cnt, 0);

        for (int k = 0; k < NV; k++) run_vec(VEC[k]);

        // R7: driver-off mid-count restarts everything
        vsel = 2'd1;
        ss   = 1'b0;
        start_off();
        wait_to(base + 30);
        zcd = 1'b0;
        wait_to(base + 34);
        zcd = 1'b1;
        wait_to(base + 40);
        start_off();
        wait_to(base + 260);
        check("R7 restart pulse edge", pulse_cyc - base, BL + 2 * TM);
        check("R7 restart pulse cycles", pulse_cnt, 1);

        // R8: a rising transition is not a valley
        vsel = 2'd0;
        @(negedge clk);
        zcd = 1'b0;
        repeat (6) @(negedge clk);
        start_off();
        wait_to(base + 30);
        zcd = 1'b1;
        wait_to(base + 260);
        check("R8 rising ignored", pulse_cyc - base, BL + TM);
        check("R8 pulse cycles", pulse_cnt, 1);

        // R4: falls while waiting after the pulse give nothing
        pulse_cnt = 0;
        for (int i = 0; i < 4; i++) begin
            repeat (6) @(negedge clk);
            zcd = 1'b0;
            repeat (6) @(negedge clk);
            zcd = 1'b1;
        end
        repeat (200) @(negedge clk);
        check("R4 no pulse after done", pulse_cnt, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk  = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule